// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds an eight-entry stack of 80-bit extended-precision registers. Each entry is addressed as ST(i) relative to a 3-bit top pointer that lives inside a 16-bit status word. Next to the registers it keeps a 16-bit control word, whose low three bits mask the invalid, denormal and divide-by-zero exceptions, and an 8-bit vector of physical valid tags. An execution pipe issues one command per clock. Each command carries an opcode, a stack index, a status word produced by the arithmetic, and up to two data values. The block folds that status into its own and decides whether the stack may move. Pushes and pops are blocked while an unmasked exception is pending. Stack faults are resolved through the invalid mask: a masked fault inserts the quiet-NaN indefinite value, and an unmasked one freezes the stack and raises the busy and summary flags.

The registers are stored by physical number and never rotated. ST(i) is the physical entry (TOP + i) mod 8. A combinational read port returns ST(rd_idx). Separate load strobes replace the control word or the status word, for example when a context is restored.

Status word bits: IE 0, DE 1, ZE 2, SF 6, ES 7, C0 8, C1 9, C2 10, TOP 13:11, C3 14, B 15. Control mask bits: IM 0, DM 1, ZM 2. QNaN indefinite is 80'hFFFF_C000_0000_0000_0000.

Top module: `fp_regstack`

## Requirements
- R1: After reset, the status word is 0 (TOP 0), the control word is 16'h037F, every tag is clear, and every register reads 0.
- R2: The merge of an incoming word clears C0..C3 (mask 16'h4700) and then ORs in the incoming word with TOP (mask 16'h3800) removed. Opcode 5 does only this merge, and TOP never changes as a result.
- R3: A push or pop is blocked when the merged word has IE, DE or ZE set and the matching IM, DM or ZM is clear. A blocked push or pop writes only the merged status, and leaves TOP, tags and registers unchanged. This covers push opcodes 3 and 4 and the pop part of opcodes 2, 6, 7, 9 and 10.
- R4: Push, opcode 3, aims at N = (TOP+7) mod 8. If tag N is clear, the block writes data 0 there, sets tag N and makes TOP equal N.
- R5: On a push to an occupied entry with IM set, the block ORs in IE, SF and C1, writes QNaN at N and still makes TOP equal N.
- R6: On a push to an occupied entry with IM clear, the status becomes the old word OR the incoming word with C and TOP removed, OR IE|SF|C1|B|ES. TOP, tags and registers stay unchanged.
- R7: A pop moves TOP to (TOP+1) mod 8 and clears the tag of the old ST(0). Opcode 6 merges and pops once, and opcode 7 merges and pops twice, checking for a block before each pop.
- R8: Store, opcode 1, merges the status, writes data 0 to ST(idx) and sets that tag without moving TOP. Opcode 2 does the same and then pops.
- R9: Underflow, opcode 8, with IM set clears C and sets IE and SF. Unless no_dest is high, it also writes QNaN to ST(idx) and sets that tag. Opcode 9 adds one pop, and opcode 10 has no destination and adds two pops.
- R10: Underflow with IM clear clears C and sets IE, SF, ES and B. It changes no register or tag, and any pop that follows is blocked.
- R11: Two-result push, opcode 4, writes data 0 to the old ST(0) and pushes data 1. On a masked overflow both positions receive QNaN.
- R12: Push-underflow (opcode 11), push-underflow-two (opcode 12) and push-overflow (opcode 13) use no incoming status. With IM set they clear C, set IE and SF, move TOP to N, set tag N and write QNaN at N. Opcode 12 also writes QNaN to the old ST(0), and opcode 13 also sets C1. With IM clear they clear C, set IE, SF, ES and B (opcode 13 also sets C1), and leave TOP unchanged.
- R13: A control-word load takes effect after the command of the same cycle, which still uses the old mask. A status-word load replaces the status and drops the command of the same cycle entirely. Opcodes 0, 14 and 15 do nothing.
- R14: rd_data always shows the register at physical (TOP + rd_idx) mod 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 4 | Command opcode, see requirements |
| cmd_idx | input | 3 | Stack-relative index i of ST(i) |
| cmd_nodest | input | 1 | Underflow without destination register |
| cmd_sw | input | 16 | Status word from the operation |
| cmd_d0 | input | 80 | First result value |
| cmd_d1 | input | 80 | Second result value (two-result push) |
| cw_we | input | 1 | Load control word |
| cw_in | input | 16 | Control word to load |
| sw_we | input | 1 | Load status word, drops the command |
| sw_in | input | 16 | Status word to load |
| rd_idx | input | 3 | Stack-relative read index |
| sw_o | output | 16 | Current status word |
| cw_o | output | 16 | Current control word |
| tag_o | output | 8 | Physical valid tags |
| rd_data | output | 80 | Contents of ST(rd_idx) |

## Verification
The directed part fills the stack and then pushes once more with the invalid mask set. A design that rechecked the old TOP or skipped the move would leave ST(0) stale instead of QNaN. The same overflow with the mask clear catches a design that still moves TOP or drops B and ES. A pop issued while an unmasked invalid flag is pending must leave TOP alone, and a masked underflow-with-pop must both write its destination and pop. The cycle where a mask load and a command coincide shows whether the old mask is used. The random mix of all opcodes covers the TOP wraparound, incoming words with noise in their TOP bits, two-result pushes and double pops.

// File: rtl/fp_regstack.sv
`timescale 1ns/1ps
module fp_regstack #(
  parameter logic [15:0] CW_RST = 16'h037F,
  parameter int          DW     = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cmd_op,
  input  logic [2:0]    cmd_idx,
  input  logic          cmd_nodest,
  input  logic [15:0]   cmd_sw,
  input  logic [DW-1:0] cmd_d0,
  input  logic [DW-1:0] cmd_d1,
  input  logic          cw_we,
  input  logic [15:0]   cw_in,
  input  logic          sw_we,
  input  logic [15:0]   sw_in,
  input  logic [2:0]    rd_idx,
  output logic [15:0]   sw_o,
  output logic [15:0]   cw_o,
  output logic [7:0]    tag_o,
  output logic [DW-1:0] rd_data
);
  localparam int          NREG   = 8;
  localparam logic [15:0] CC_M   = 16'h4700;
  localparam logic [15:0] TOP_M  = 16'h3800;
  localparam logic [15:0] F_IS   = 16'h0041;
  localparam logic [15:0] F_C1   = 16'h0200;
  localparam logic [15:0] F_BES  = 16'h8080;
  localparam logic [DW-1:0] QNAN = {1'b1, 15'h7FFF, 2'b11, {(DW-18){1'b0}}};

  localparam logic [3:0] OP_ST   = 4'd1, OP_STP  = 4'd2, OP_PSH  = 4'd3, OP_PSH2 = 4'd4,
                         OP_SW   = 4'd5, OP_SWP  = 4'd6, OP_SWPP = 4'd7, OP_UF   = 4'd8,
                         OP_UFP  = 4'd9, OP_UFPP = 4'd10, OP_PUF = 4'd11, OP_PUF2 = 4'd12,
                         OP_POF  = 4'd13;

  logic [15:0]   sw_q, cw_q;
  logic [7:0]    tag_q;
  logic [DW-1:0] regs [NREG];

  logic [2:0]    top, ntop;
  logic          im;
  logic [15:0]   mrg, sw_n, s1, s2;
  logic [7:0]    tag_n, t1, t2;
  logic [1:0]    npop;
  logic          wa_en, wb_en;
  logic [2:0]    wa_ad, wb_ad;
  logic [DW-1:0] wa_d, wb_d;

  function automatic logic blocked(input logic [15:0] s, input logic [15:0] c);
    return |(s[2:0] & ~c[2:0]);
  endfunction

  assign top  = sw_q[13:11];
  assign ntop = top - 3'd1;
  assign im   = cw_q[0];
  assign mrg  = (sw_q & ~CC_M) | (cmd_sw & ~TOP_M);

  always_comb begin
    sw_n  = sw_q;
    tag_n = tag_q;
    npop  = 2'd0;
    wa_en = 1'b0; wa_ad = 3'd0; wa_d = '0;
    wb_en = 1'b0; wb_ad = 3'd0; wb_d = '0;
    case (cmd_op)
      OP_ST, OP_STP: begin
        sw_n  = mrg;
        wa_en = 1'b1;
        wa_ad = top + cmd_idx;
        wa_d  = cmd_d0;
        tag_n[top + cmd_idx] = 1'b1;
        npop  = (cmd_op == OP_STP) ? 2'd1 : 2'd0;
      end
      OP_PSH, OP_PSH2: begin
        sw_n = mrg;
        if (!blocked(mrg, cw_q)) begin
          if (!tag_q[ntop] || im) begin
            wa_en = 1'b1;
            wa_ad = ntop;
            wb_en = (cmd_op == OP_PSH2);
            wb_ad = top;
            sw_n[13:11] = ntop;
            if (!tag_q[ntop]) begin
              tag_n[ntop] = 1'b1;
              wa_d = (cmd_op == OP_PSH2) ? cmd_d1 : cmd_d0;
              wb_d = cmd_d0;
            end else begin
              sw_n = sw_n | F_IS | F_C1;
              wa_d = QNAN;
              wb_d = QNAN;
            end
          end else begin
            sw_n = sw_q | (cmd_sw & ~(CC_M | TOP_M)) | F_IS | F_C1 | F_BES;
          end
        end
      end
      OP_SW, OP_SWP, OP_SWPP: begin
        sw_n = mrg;
        npop = (cmd_op == OP_SW) ? 2'd0 : (cmd_op == OP_SWP) ? 2'd1 : 2'd2;
      end
      OP_UF, OP_UFP, OP_UFPP: begin
        sw_n = (sw_q & ~CC_M) | F_IS | (im ? 16'h0 : F_BES);
        if (im && !cmd_nodest && cmd_op != OP_UFPP) begin
          wa_en = 1'b1;
          wa_ad = top + cmd_idx;
          wa_d  = QNAN;
          tag_n[top + cmd_idx] = 1'b1;
        end
        npop = (cmd_op == OP_UF) ? 2'd0 : (cmd_op == OP_UFP) ? 2'd1 : 2'd2;
      end
      OP_PUF, OP_PUF2, OP_POF: begin
        if (im) begin
          sw_n = (sw_q & ~(CC_M | TOP_M)) | F_IS | ((cmd_op == OP_POF) ? F_C1 : 16'h0);
          sw_n[13:11] = ntop;
          tag_n[ntop] = 1'b1;
          wa_en = 1'b1;
          wa_ad = ntop;
          wa_d  = QNAN;
          wb_en = (cmd_op == OP_PUF2);
          wb_ad = top;
          wb_d  = QNAN;
        end else begin
          sw_n = (sw_q & ~CC_M) | F_IS | F_BES | ((cmd_op == OP_POF) ? F_C1 : 16'h0);
        end
      end
      default: ;
    endcase

    s1 = sw_n;
    t1 = tag_n;
    if (npop != 2'd0 && !blocked(s1, cw_q)) begin
      t1[s1[13:11]] = 1'b0;
      s1[13:11] = s1[13:11] + 3'd1;
    end
    s2 = s1;
    t2 = t1;
    if (npop == 2'd2 && !blocked(s2, cw_q)) begin
      t2[s2[13:11]] = 1'b0;
      s2[13:11] = s2[13:11] + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= '0;
      cw_q  <= CW_RST;
      tag_q <= '0;
    end else begin
      if (cw_we) cw_q <= cw_in;
      if (sw_we) sw_q <= sw_in;
      else begin
        sw_q  <= s2;
        tag_q <= t2;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (!sw_we && wa_en && wa_ad == 3'(g)) regs[g] <= wa_d;
      else if (!sw_we && wb_en && wb_ad == 3'(g)) regs[g] <= wb_d;
    end
  end

  logic [2:0] rd_ad;
  assign rd_ad   = top + rd_idx;
  assign rd_data = regs[rd_ad];
  assign sw_o    = sw_q;
  assign cw_o    = cw_q;
  assign tag_o   = tag_q;
endmodule

// File: rtl/fp_regstack_chk.sv
`timescale 1ns/1ps
module fp_regstack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cmd_op,
  input logic [15:0] cmd_sw,
  input logic        sw_we,
  input logic [15:0] sw_in,
  input logic [15:0] sw_o,
  input logic [15:0] cw_o,
  input logic [7:0]  tag_o
);
  logic [15:0] mrg;
  logic        pnd;
  logic [2:0]  top, ntop;
  assign mrg  = (sw_o & ~16'h4700) | (cmd_sw & ~16'h3800);
  assign pnd  = |(mrg[2:0] & ~cw_o[2:0]);
  assign top  = sw_o[13:11];
  assign ntop = top - 3'd1;

  // R13
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> sw_o == $past(sw_in));

  // R2
  merge_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && cmd_op == 4'd5) |=> (sw_o[13:11] == $past(top)) &&
      ((sw_o & ~16'h3800) == ($past(mrg) & ~16'h3800)));

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && (cmd_op == 4'd6 || cmd_op == 4'd7) && pnd) |=>
      $stable(tag_o) && sw_o[13:11] == $past(top));

  // R7
  pop_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && cmd_op == 4'd6 && !pnd) |=>
      sw_o[13:11] == 3'($past(top) + 3'd1));

  // R6
  ovf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && cmd_op == 4'd3 && !pnd && tag_o[ntop] && !cw_o[0]) |=>
      $stable(tag_o) && sw_o[13:11] == $past(top) && sw_o[15] && sw_o[7]);

  // R10
  uf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && cmd_op == 4'd8 && !cw_o[0]) |=>
      $stable(tag_o) && ((sw_o & 16'h80C1) == 16'h80C1));
endmodule

bind fp_regstack fp_regstack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_sw(cmd_sw),
  .sw_we(sw_we), .sw_in(sw_in), .sw_o(sw_o), .cw_o(cw_o), .tag_o(tag_o)
);

// File: tb/tb_fp_regstack.sv
`timescale 1ns/1ps
module tb_fp_regstack;
  localparam logic [79:0] QNAN = 80'hFFFF_C000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic        cmd_nodest = 1'b0;
  logic [15:0] cmd_sw = '0;
  logic [79:0] cmd_d0 = '0, cmd_d1 = '0;
  logic        cw_we = 1'b0, sw_we = 1'b0;
  logic [15:0] cw_in = '0, sw_in = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] sw_o, cw_o;
  logic [7:0]  tag_o;
  logic [79:0] rd_data;

  int errs = 0, checks = 0;

  logic [79:0] mr [8];
  logic [7:0]  mt;
  logic [15:0] ms, mc;

  always #2.5 clk = ~clk;

  fp_regstack dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_nodest(cmd_nodest),
    .cmd_sw(cmd_sw), .cmd_d0(cmd_d0), .cmd_d1(cmd_d1), .cw_we(cw_we), .cw_in(cw_in),
    .sw_we(sw_we), .sw_in(sw_in), .rd_idx(rd_idx), .sw_o(sw_o), .cw_o(cw_o),
    .tag_o(tag_o), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic blk(input logic [15:0] s);
    return |(s[2:0] & ~mc[2:0]);
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd2:         return "R8";
      4'd3:               return "R4";
      4'd4:               return "R11";
      4'd5:               return "R2";
      4'd6, 4'd7:         return "R7";
      4'd8, 4'd9, 4'd10:  return "R9";
      4'd11, 4'd12, 4'd13:return "R12";
      default:            return "R13";
    endcase
  endfunction

  task automatic m_step();
    logic [15:0] s;
    logic [2:0]  t, n;
    int          pops;
    t = ms[13:11];
    n = t - 3'd1;
    pops = 0;
    if (sw_we) ms = sw_in;
    else begin
      s = ms;
      case (cmd_op)
        4'd1, 4'd2: begin
          s = (ms & ~16'h4700) | (cmd_sw & ~16'h3800);
          mr[3'(t + cmd_idx)] = cmd_d0;
          mt[3'(t + cmd_idx)] = 1'b1;
          pops = (cmd_op == 4'd2) ? 1 : 0;
        end
        4'd3, 4'd4: begin
          s = (ms & ~16'h4700) | (cmd_sw & ~16'h3800);
          if (!blk(s)) begin
            if (!mt[n]) begin
              mt[n] = 1'b1;
              mr[n] = (cmd_op == 4'd4) ? cmd_d1 : cmd_d0;
              if (cmd_op == 4'd4) mr[t] = cmd_d0;
              s[13:11] = n;
            end else if (mc[0]) begin
              s = s | 16'h0241;
              mr[n] = QNAN;
              if (cmd_op == 4'd4) mr[t] = QNAN;
              s[13:11] = n;
            end else s = ms | (cmd_sw & 16'h80FF) | 16'h82C1;
          end
        end
        4'd5, 4'd6, 4'd7: begin
          s = (ms & ~16'h4700) | (cmd_sw & ~16'h3800);
          pops = int'(cmd_op) - 5;
        end
        4'd8, 4'd9, 4'd10: begin
          s = (ms & ~16'h4700) | (mc[0] ? 16'h0041 : 16'h80C1);
          if (mc[0] && !cmd_nodest && cmd_op != 4'd10) begin
            mr[3'(t + cmd_idx)] = QNAN;
            mt[3'(t + cmd_idx)] = 1'b1;
          end
          pops = int'(cmd_op) - 8;
        end
        4'd11, 4'd12, 4'd13: begin
          if (mc[0]) begin
            s = (ms & ~16'h7F00) | 16'h0041 | ((cmd_op == 4'd13) ? 16'h0200 : 16'h0);
            s[13:11] = n;
            mt[n] = 1'b1;
            mr[n] = QNAN;
            if (cmd_op == 4'd12) mr[t] = QNAN;
          end else s = (ms & ~16'h4700) | 16'h80C1 | ((cmd_op == 4'd13) ? 16'h0200 : 16'h0);
        end
        default: ;
      endcase
      for (int k = 0; k < pops; k++) begin
        if (!blk(s)) begin
          mt[s[13:11]] = 1'b0;
          s[13:11] = s[13:11] + 3'd1;
        end
      end
      ms = s;
    end
    if (cw_we) mc = cw_in;
  endtask

  // Drive one command with optional loads, clock it, update the model, compare.
  task automatic apply(input logic [3:0] op, input logic [2:0] idx, input logic nd,
                       input logic [15:0] isw, input logic [79:0] a, input logic [79:0] b,
                       input logic swl, input logic [15:0] swv,
                       input logic cwl, input logic [15:0] cwv);
    string r;
    cmd_op = op; cmd_idx = idx; cmd_nodest = nd; cmd_sw = isw;
    cmd_d0 = a; cmd_d1 = b; sw_we = swl; sw_in = swv; cw_we = cwl; cw_in = cwv;
    @(posedge clk);
    #1;
    m_step();
    r = swl ? "R13" : req_of(op);
    cmd_op = '0; sw_we = 1'b0; cw_we = 1'b0;
    chk(r, {64'h0, sw_o}, {64'h0, ms});
    chk(r, {64'h0, cw_o}, {64'h0, mc});
    chk(r, {72'h0, tag_o}, {72'h0, mt});
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.1;
      chk("R14", rd_data, mr[3'(ms[13:11] + 3'(i))]);
    end
  endtask

  task automatic rd_st(input logic [2:0] i, output logic [79:0] v);
    rd_idx = i;
    #0.1;
    v = rd_data;
  endtask

  initial begin
    #(5.0 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [79:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mr[i] = '0;
    mt = '0; ms = '0; mc = 16'h037F;
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1", {64'h0, sw_o}, 80'h0);
    chk("R1", {64'h0, cw_o}, 80'h037F);
    chk("R1", {72'h0, tag_o}, 80'h0);
    rd_st(3'd5, v);
    chk("R1", v, 80'h0);

    // R4 fill all eight entries
    for (int i = 0; i < 8; i++)
      apply(4'd3, 3'd0, 1'b0, 16'h0, {16'h1000, 64'(i)}, '0, 1'b0, '0, 1'b0, '0);
    chk("R4", {72'h0, tag_o}, 80'hFF);
    chk("R4", {77'h0, sw_o[13:11]}, 80'h0);
    rd_st(3'd0, v);
    chk("R4", v, {16'h1000, 64'd7});

    // R5 masked overflow: QNaN pushed, TOP moves to 7
    apply(4'd3, 3'd0, 1'b0, 16'h0, 80'h1234, '0, 1'b0, '0, 1'b0, '0);
    chk("R5", {64'h0, sw_o}, 80'h3A41);
    rd_st(3'd0, v);
    chk("R5", v, QNAN);

    // R6 unmasked overflow: frozen, B and ES raised
    apply(4'd0, 3'd0, 1'b0, 16'h0, '0, '0, 1'b1, 16'h3800, 1'b1, 16'h037E);
    apply(4'd3, 3'd0, 1'b0, 16'h0, 80'h5555, '0, 1'b0, '0, 1'b0, '0);
    chk("R6", {64'h0, sw_o}, 80'hBAC1);
    chk("R6", {72'h0, tag_o}, 80'hFF);
    rd_st(3'd0, v);
    chk("R6", v, QNAN);

    // R3 pending unmasked IE blocks pop
    apply(4'd6, 3'd0, 1'b0, 16'h0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R3", {64'h0, sw_o}, 80'hB8C1);
    chk("R3", {72'h0, tag_o}, 80'hFF);

    // R10 unmasked underflow leaves registers alone
    apply(4'd0, 3'd0, 1'b0, 16'h0, '0, '0, 1'b1, 16'h3800, 1'b0, '0);
    apply(4'd8, 3'd0, 1'b0, 16'h0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R10", {64'h0, sw_o}, 80'hB8C1);
    chk("R10", {72'h0, tag_o}, 80'hFF);

    // R9 masked underflow with destination, then pop
    apply(4'd0, 3'd0, 1'b0, 16'h0, '0, '0, 1'b1, 16'h3800, 1'b1, 16'h037F);
    apply(4'd9, 3'd1, 1'b0, 16'h0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R9", {64'h0, sw_o}, 80'h0041);
    chk("R9", {72'h0, tag_o}, 80'h7F);
    rd_st(3'd0, v);
    chk("R9", v, QNAN);

    // R13 mask load in the same cycle does not affect that command
    apply(4'd13, 3'd0, 1'b0, 16'h0, '0, '0, 1'b0, '0, 1'b1, 16'h037E);
    chk("R13", {64'h0, sw_o}, 80'h3A41);
    chk("R13", {64'h0, cw_o}, 80'h037E);
    // R13 status load drops the command
    apply(4'd3, 3'd0, 1'b0, 16'h0, 80'h77, '0, 1'b1, 16'h0000, 1'b1, 16'h037F);
    chk("R13", {64'h0, sw_o}, 80'h0);
    chk("R13", {72'h0, tag_o}, 80'hFF);

    // Random mix of all opcodes
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  op;
      logic [15:0] isw;
      logic        swl, cwl;
      logic [15:0] cwv;
      op  = 4'($urandom % 16);
      isw = 16'($urandom);
      if (($urandom % 10) != 0) isw[2:0] = 3'b000;
      swl = (($urandom % 24) == 0);
      cwl = (($urandom % 16) == 0);
      cwv = {13'h006F, 2'($urandom), (($urandom % 4) != 0)};
      apply(op, 3'($urandom), (($urandom % 4) == 0), isw,
            {16'($urandom), 32'($urandom), 32'($urandom)},
            {16'($urandom), 32'($urandom), 32'($urandom)},
            swl, {2'($urandom), 3'($urandom), 8'($urandom), 3'b000}, cwl, cwv);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule